// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Cache

This block is the translation cache that sits in front of a device IOMMU's page walker. It keeps translations for 4 KiB, 2 MiB and 1 GiB pages side by side in one small fully associative array. A requester presents a 16-bit source ID and an input page frame. One cycle later the block reports hit or miss. On a hit it also returns the input page base aligned to the page size of the matching entry, the translated page base, the in-page offset mask and a two-bit permission code.

After an external walk the fill port installs a translation. A fill carries its source ID, domain ID, input frame, the leaf base taken from bits 38:12 of the leaf entry, read and write flags, and the paging level: 1 for 4 KiB, 2 for 2 MiB, 3 for 1 GiB. Each stored entry keeps its level and its page mask as part of its tag, so a lookup probes all three alignments at once. When more than one level matches, the smallest page wins. A page-selective invalidation removes the entries of one domain that fall inside a power-of-two range of 4 KiB frames. It also removes any large page that covers the invalidated address. A flush empties the whole array.

Top module: `iotlb_cache`

## Requirements
- R1: After reset, and in the cycle after a flush, every lookup misses (`lk_hit` = 0).
- R2: A lookup hits only on a valid entry with the same source ID and level whose stored frame equals the request frame with the low 9×(level−1) frame bits cleared. A different source ID or an uncovered frame misses.
- R3: When entries of several levels match, the level-1 entry is used before level 2, and level 2 before level 3.
- R4: The result appears one cycle after `lk_valid`, with `lk_done` = 1. On a hit, `lk_iova` is the input address with every bit below 12+9×(level−1) cleared, and `lk_pa` is the stored leaf base cleared the same way. `lk_off_mask` is the bitwise inverse of that page mask over 39 bits. `lk_perm` is {write, read}: bit 1 is write, bit 0 is read. On a miss, all four of these are zero.
- R5: A fill whose source ID, level and aligned frame equal those of a valid entry replaces that entry's domain, leaf base and permissions, and the old values are no longer returned.
- R6: A fill with level 0 or level 4 to 7 changes nothing, so a lookup of its frame still misses.
- R7: The array holds 16 entries. A fill without a tag match takes the lowest free slot. When no slot is free, it overwrites the slot named by a victim pointer. The pointer starts at 0 on reset, advances by one with wrap only when used, and is not changed by a flush.
- R8: An invalidation with order am removes a valid entry of the same domain when the entry frame and the request frame are equal after both have their low am bits cleared.
- R9: An invalidation also removes a valid entry of the same domain when the entry frame equals the request frame ANDed with that entry's own page mask, even when am = 0.
- R10: An invalidation never removes an entry whose domain ID differs.
- R11: An invalidation with am above 18 removes nothing, and it raises `iv_reject` for one cycle in the following cycle. A valid invalidation with am of 18 or less leaves `iv_reject` at 0.
- R12: A lookup presented in the same cycle as an invalidation or a flush is answered from the contents before that operation.
- R13: A fill presented together with a flush is dropped. A fill presented together with an invalidation is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear every entry |
| lk_valid | input | 1 | Lookup request |
| lk_sid | input | 16 | Lookup source ID |
| lk_addr | input | 27 | Lookup input address bits 38:12 |
| fl_valid | input | 1 | Fill request |
| fl_sid | input | 16 | Fill source ID |
| fl_did | input | 16 | Fill domain ID |
| fl_addr | input | 27 | Fill input address bits 38:12 |
| fl_leaf_base | input | 27 | Leaf entry bits 38:12 (translated base) |
| fl_rd | input | 1 | Fill read permission |
| fl_wr | input | 1 | Fill write permission |
| fl_level | input | 3 | Fill paging level, 1 to 3 valid |
| iv_valid | input | 1 | Page-selective invalidation request |
| iv_did | input | 16 | Invalidation domain ID |
| iv_addr | input | 27 | Invalidation address bits 38:12 |
| iv_am | input | 5 | Invalidation address-mask order |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_iova | output | 39 | Aligned input page address |
| lk_pa | output | 39 | Aligned translated page address |
| lk_off_mask | output | 39 | In-page offset mask |
| lk_perm | output | 2 | {write, read} |
| iv_reject | output | 1 | Invalidation refused, am above 18 |

## Verification
A lookup can land in the same cycle as an invalidation or a flush that removes the very entry it matches. The bench drives both requests on one falling edge. It expects the hit data from the contents before the operation, then looks up the same address again and expects the reduced contents. Fill against flush and fill against invalidation are provoked the same way, and a follow-up lookup shows which one won. All expected results come from an arithmetic model of the array that the bench updates in the order the requirements fix.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    localparam int AW       = 39;
    localparam int SID_W    = 16;
    localparam int DID_W    = 16;
    localparam int PG_SHIFT = 12;
    localparam int LVL_BITS = 9;
    localparam int NUM_LVL  = 3;
    localparam int AM_W     = 5;
    localparam int LVLIN_W  = 3;
    localparam int PFN_W    = AW - PG_SHIFT;

    typedef logic [PFN_W-1:0] pfn_t;

    // Tag side of one cache slot: everything compared on lookup/invalidate/fill.
    typedef struct packed {
        logic             vld;
        logic [SID_W-1:0] sid;
        logic [DID_W-1:0] did;
        logic [1:0]       lvl;
        pfn_t             pfn;
        pfn_t             pmask;
    } tag_t;

    // Payload side of one cache slot.
    typedef struct packed {
        pfn_t pa;
        logic rd;
        logic wr;
    } payload_t;

    typedef struct packed {
        logic hit;
        pfn_t pmask;
        pfn_t pa;
        logic rd;
        logic wr;
    } result_t;

    // Page mask in frame units for level 1..3.
    function automatic pfn_t lvl_pfn_mask(input logic [1:0] lvl);
        pfn_t m;
        m = '1;
        case (lvl)
            2'd2:    m = m << LVL_BITS;
            2'd3:    m = m << (2 * LVL_BITS);
            default: m = '1;
        endcase
        return m;
    endfunction

    // Range mask in frame units for an invalidation order.
    function automatic pfn_t am_pfn_mask(input logic [AM_W-1:0] am);
        pfn_t m;
        m = '1;
        return m << am;
    endfunction

endpackage

// File: rtl/iotlb_match.sv
module iotlb_match
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  tag_t [ENTRIES-1:0]                lk_tags,
    input  logic [SID_W-1:0]                  lk_sid,
    input  pfn_t                              lk_pfn,
    input  logic [DID_W-1:0]                  iv_did,
    input  pfn_t                              iv_pfn,
    input  pfn_t                              iv_amask,
    input  logic [SID_W-1:0]                  fl_sid,
    input  logic [1:0]                        fl_lvl,
    input  pfn_t                              fl_pfn,
    output logic [NUM_LVL-1:0][ENTRIES-1:0]   lk_hit,
    output logic [ENTRIES-1:0]                iv_hit,
    output logic [ENTRIES-1:0]                fl_hit
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tag_t t;
        assign t = lk_tags[g];

        for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
            localparam logic [1:0] LV = 2'(l + 1);
            assign lk_hit[l][g] = t.vld && (t.sid == lk_sid) && (t.lvl == LV) &&
                                  (t.pfn == (lk_pfn & lvl_pfn_mask(LV)));
        end

        logic in_range, covers;
        assign in_range   = ((t.pfn & iv_amask) == (iv_pfn & iv_amask));
        assign covers     = (t.pfn == (iv_pfn & t.pmask));
        assign iv_hit[g]  = t.vld && (t.did == iv_did) && (in_range || covers);

        assign fl_hit[g]  = t.vld && (t.sid == fl_sid) && (t.lvl == fl_lvl) &&
                            (t.pfn == fl_pfn);
    end

endmodule

// File: rtl/iotlb_alloc.sv
module iotlb_alloc
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] slot_vld,
    input  logic [ENTRIES-1:0] tag_hit,
    input  logic [IW-1:0]      victim,
    output logic [IW-1:0]      slot,
    output logic               use_victim
);

    logic [IW-1:0] hit_idx, free_idx;
    logic          any_hit, any_free;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        any_hit  = 1'b0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (tag_hit[i]) begin
                hit_idx = IW'(i);
                any_hit = 1'b1;
            end
            if (!slot_vld[i]) begin
                free_idx = IW'(i);
                any_free = 1'b1;
            end
        end
        if (any_hit) begin
            slot       = hit_idx;
            use_victim = 1'b0;
        end else if (any_free) begin
            slot       = free_idx;
            use_victim = 1'b0;
        end else begin
            slot       = victim;
            use_victim = 1'b1;
        end
    end

endmodule

// File: rtl/iotlb_select.sv
module iotlb_select
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  payload_t [ENTRIES-1:0]            pay,
    input  logic [NUM_LVL-1:0][ENTRIES-1:0]   lk_hit,
    output result_t                           res
);

    always_comb begin
        pfn_t pa_acc;
        logic rd_acc, wr_acc;
        res = '0;
        // Walk from the largest page down so that the smallest matching page wins.
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            pa_acc = '0;
            rd_acc = 1'b0;
            wr_acc = 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (lk_hit[l][i]) begin
                    pa_acc = pa_acc | pay[i].pa;
                    rd_acc = rd_acc | pay[i].rd;
                    wr_acc = wr_acc | pay[i].wr;
                end
            end
            if (|lk_hit[l]) begin
                res.hit   = 1'b1;
                res.pmask = lvl_pfn_mask(2'(l + 1));
                res.pa    = pa_acc;
                res.rd    = rd_acc;
                res.wr    = wr_acc;
            end
        end
    end

endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int MAX_AM  = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 lk_valid,
    input  logic [SID_W-1:0]     lk_sid,
    input  logic [AW-1:PG_SHIFT] lk_addr,
    input  logic                 fl_valid,
    input  logic [SID_W-1:0]     fl_sid,
    input  logic [DID_W-1:0]     fl_did,
    input  logic [AW-1:PG_SHIFT] fl_addr,
    input  logic [AW-1:PG_SHIFT] fl_leaf_base,
    input  logic                 fl_rd,
    input  logic                 fl_wr,
    input  logic [LVLIN_W-1:0]   fl_level,
    input  logic                 iv_valid,
    input  logic [DID_W-1:0]     iv_did,
    input  logic [AW-1:PG_SHIFT] iv_addr,
    input  logic [AM_W-1:0]      iv_am,
    output logic                 lk_done,
    output logic                 lk_hit,
    output logic [AW-1:0]        lk_iova,
    output logic [AW-1:0]        lk_pa,
    output logic [AW-1:0]        lk_off_mask,
    output logic [1:0]           lk_perm,
    output logic                 iv_reject
);

    localparam int IW = $clog2(ENTRIES);
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    tag_t     [ENTRIES-1:0] tag_q;
    payload_t [ENTRIES-1:0] pay_q;
    logic     [IW-1:0]      rr_q;

    // Request decode
    logic       fl_ok, iv_ok, iv_bad;
    logic [1:0] fl_lvl;
    pfn_t       fl_pmask, fl_pfn;

    assign fl_lvl   = fl_level[1:0];
    assign fl_ok    = fl_valid && (fl_level != '0) && (fl_level <= LVLIN_W'(NUM_LVL));
    assign fl_pmask = lvl_pfn_mask(fl_lvl);
    assign fl_pfn   = fl_addr & fl_pmask;
    assign iv_bad   = (int'(iv_am) > MAX_AM);
    assign iv_ok    = iv_valid && !iv_bad;

    logic [NUM_LVL-1:0][ENTRIES-1:0] lk_hit_v;
    logic [ENTRIES-1:0]              iv_hit_v, fl_hit_v, vld_v;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign vld_v[g] = tag_q[g].vld;
    end

    iotlb_match #(.ENTRIES(ENTRIES)) u_match (
        .lk_tags  (tag_q),
        .lk_sid   (lk_sid),
        .lk_pfn   (lk_addr),
        .iv_did   (iv_did),
        .iv_pfn   (iv_addr),
        .iv_amask (am_pfn_mask(iv_am)),
        .fl_sid   (fl_sid),
        .fl_lvl   (fl_lvl),
        .fl_pfn   (fl_pfn),
        .lk_hit   (lk_hit_v),
        .iv_hit   (iv_hit_v),
        .fl_hit   (fl_hit_v)
    );

    logic [IW-1:0] fl_slot;
    logic          fl_victim;

    iotlb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .slot_vld   (vld_v),
        .tag_hit    (fl_hit_v),
        .victim     (rr_q),
        .slot       (fl_slot),
        .use_victim (fl_victim)
    );

    result_t res;

    iotlb_select #(.ENTRIES(ENTRIES)) u_sel (
        .pay    (pay_q),
        .lk_hit (lk_hit_v),
        .res    (res)
    );

    tag_t     new_tag;
    payload_t new_pay;
    logic     give_hit;

    assign new_tag  = '{vld: 1'b1, sid: fl_sid, did: fl_did, lvl: fl_lvl,
                        pfn: fl_pfn, pmask: fl_pmask};
    assign new_pay  = '{pa: fl_leaf_base, rd: fl_rd, wr: fl_wr};
    assign give_hit = lk_valid && res.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q       <= '0;
            pay_q       <= '0;
            rr_q        <= '0;
            lk_done     <= 1'b0;
            lk_hit      <= 1'b0;
            lk_iova     <= '0;
            lk_pa       <= '0;
            lk_off_mask <= '0;
            lk_perm     <= '0;
            iv_reject   <= 1'b0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush || (iv_ok && iv_hit_v[i])) begin
                    tag_q[i].vld <= 1'b0;
                end
            end
            if (fl_ok && !flush) begin
                tag_q[fl_slot] <= new_tag;
                pay_q[fl_slot] <= new_pay;
                if (fl_victim) begin
                    rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
                end
            end

            lk_done     <= lk_valid;
            lk_hit      <= give_hit;
            lk_iova     <= give_hit ? {lk_addr & res.pmask, {PG_SHIFT{1'b0}}} : '0;
            lk_pa       <= give_hit ? {res.pa & res.pmask, {PG_SHIFT{1'b0}}} : '0;
            lk_off_mask <= give_hit ? ~{res.pmask, {PG_SHIFT{1'b0}}} : '0;
            lk_perm     <= give_hit ? {res.wr, res.rd} : 2'b00;
            iv_reject   <= iv_valid && iv_bad;
        end
    end

endmodule

// File: rtl/iotlb_cache_chk.sv
module iotlb_cache_chk
    import iotlb_pkg::*;
#(
    parameter int MAX_AM = 18
) (
    input logic            clk,
    input logic            rst,
    input logic            flush,
    input logic            lk_valid,
    input logic            lk_done,
    input logic            lk_hit,
    input logic [AW-1:0]   lk_iova,
    input logic [AW-1:0]   lk_pa,
    input logic [AW-1:0]   lk_off_mask,
    input logic            iv_valid,
    input logic [AM_W-1:0] iv_am,
    input logic            iv_reject
);

    p_done_follows_req_r4: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_done);

    p_no_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_done);

    p_hit_needs_done_r2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_done);

    p_mask_shape_r4: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_off_mask[PG_SHIFT-1:0] == '1) &&
                   (($countones(lk_off_mask) == 12) || ($countones(lk_off_mask) == 21) ||
                    ($countones(lk_off_mask) == 30)));

    p_bases_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ((lk_iova & lk_off_mask) == '0) && ((lk_pa & lk_off_mask) == '0));

    p_flush_empties_r1: assert property (@(posedge clk) disable iff (rst)
        flush ##1 lk_valid |=> !lk_hit);

    p_reject_bad_am_r11: assert property (@(posedge clk) disable iff (rst)
        (iv_valid && (int'(iv_am) > MAX_AM)) |=> iv_reject);

    p_no_reject_r11: assert property (@(posedge clk) disable iff (rst)
        !(iv_valid && (int'(iv_am) > MAX_AM)) |=> !iv_reject);

endmodule

bind iotlb_cache iotlb_cache_chk #(.MAX_AM(MAX_AM)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .lk_valid    (lk_valid),
    .lk_done     (lk_done),
    .lk_hit      (lk_hit),
    .lk_iova     (lk_iova),
    .lk_pa       (lk_pa),
    .lk_off_mask (lk_off_mask),
    .iv_valid    (iv_valid),
    .iv_am       (iv_am),
    .iv_reject   (iv_reject)
);

// File: tb/tb_iotlb_cache.sv
module tb_iotlb_cache;

    localparam int N = 16;

    logic        clk = 0;
    logic        rst = 1;
    logic        flush = 0;
    logic        lk_valid = 0;
    logic [15:0] lk_sid = 0;
    logic [38:12] lk_addr = 0;
    logic        fl_valid = 0;
    logic [15:0] fl_sid = 0, fl_did = 0;
    logic [38:12] fl_addr = 0, fl_leaf_base = 0;
    logic        fl_rd = 0, fl_wr = 0;
    logic [2:0]  fl_level = 0;
    logic        iv_valid = 0;
    logic [15:0] iv_did = 0;
    logic [38:12] iv_addr = 0;
    logic [4:0]  iv_am = 0;
    logic        lk_done, lk_hit, iv_reject;
    logic [38:0] lk_iova, lk_pa, lk_off_mask;
    logic [1:0]  lk_perm;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    iotlb_cache dut (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_valid(lk_valid), .lk_sid(lk_sid), .lk_addr(lk_addr),
        .fl_valid(fl_valid), .fl_sid(fl_sid), .fl_did(fl_did), .fl_addr(fl_addr),
        .fl_leaf_base(fl_leaf_base), .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_level(fl_level),
        .iv_valid(iv_valid), .iv_did(iv_did), .iv_addr(iv_addr), .iv_am(iv_am),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_iova(lk_iova), .lk_pa(lk_pa),
        .lk_off_mask(lk_off_mask), .lk_perm(lk_perm), .iv_reject(iv_reject)
    );

    // Reference model of the array, updated in the order the requirements give.
    logic        m_vld [N];
    logic [15:0] m_sid [N];
    logic [15:0] m_did [N];
    int          m_lvl [N];
    logic [26:0] m_pfn [N];
    logic [26:0] m_pa  [N];
    logic        m_rd  [N];
    logic        m_wr  [N];
    int          m_rr = 0;

    function automatic logic [26:0] pm(input int l);
        logic [26:0] m;
        m = '1;
        return m << (9 * (l - 1));
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    endfunction

    function automatic void m_fill(input [15:0] sid, did, input [38:0] addr, leaf,
                                   input rd, wr, input int lvl);
        int slot;
        logic [26:0] pf;
        if (lvl < 1 || lvl > 3) return;
        pf = addr[38:12] & pm(lvl);
        slot = -1;
        for (int i = 0; i < N; i++)
            if (slot < 0 && m_vld[i] && m_sid[i] == sid && m_lvl[i] == lvl && m_pfn[i] == pf)
                slot = i;
        for (int i = 0; i < N; i++)
            if (slot < 0 && !m_vld[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_vld[slot] = 1'b1; m_sid[slot] = sid; m_did[slot] = did; m_lvl[slot] = lvl;
        m_pfn[slot] = pf; m_pa[slot] = leaf[38:12]; m_rd[slot] = rd; m_wr[slot] = wr;
    endfunction

    function automatic void m_inval(input [15:0] did, input [38:0] addr, input int am);
        logic [26:0] rq, amk;
        if (am > 18) return;
        rq = addr[38:12];
        amk = 27'h7FF_FFFF << am;
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_did[i] == did &&
                (((m_pfn[i] & amk) == (rq & amk)) || (m_pfn[i] == (rq & pm(m_lvl[i])))))
                m_vld[i] = 1'b0;
    endfunction

    function automatic void chk_lk(input [15:0] sid, input [38:0] addr, input string rq);
        logic eh;
        logic [38:0] ei, ep, eo;
        logic [1:0] eperm;
        eh = 0; ei = 0; ep = 0; eo = 0; eperm = 0;
        for (int l = 3; l >= 1; l--)
            for (int i = 0; i < N; i++)
                if (m_vld[i] && m_sid[i] == sid && m_lvl[i] == l &&
                    m_pfn[i] == (addr[38:12] & pm(l))) begin
                    eh = 1;
                    ei = {addr[38:12] & pm(l), 12'h000};
                    ep = {m_pa[i] & pm(l), 12'h000};
                    eo = ~{pm(l), 12'h000};
                    eperm = {m_wr[i], m_rd[i]};
                end
        checks++;
        if ({lk_done, lk_hit, lk_iova, lk_pa, lk_off_mask, lk_perm} !==
            {1'b1, eh, ei, ep, eo, eperm}) begin
            errors++;
            $display("FAIL %s sid=%h addr=%h: got done=%b hit=%b iova=%h pa=%h off=%h perm=%b, expected done=1 hit=%b iova=%h pa=%h off=%h perm=%b",
                     rq, sid, addr, lk_done, lk_hit, lk_iova, lk_pa, lk_off_mask, lk_perm,
                     eh, ei, ep, eo, eperm);
        end
    endfunction

    task automatic look(input [15:0] sid, input [38:0] addr, input string rq);
        lk_valid = 1; lk_sid = sid; lk_addr = addr[38:12];
        @(negedge clk);
        lk_valid = 0;
        chk_lk(sid, addr, rq);
    endtask

    task automatic hw_fill(input [15:0] sid, did, input [38:0] addr, leaf,
                           input rd, wr, input int lvl);
        fl_valid = 1; fl_sid = sid; fl_did = did; fl_addr = addr[38:12];
        fl_leaf_base = leaf[38:12]; fl_rd = rd; fl_wr = wr; fl_level = 3'(lvl);
        @(negedge clk);
        fl_valid = 0;
        m_fill(sid, did, addr, leaf, rd, wr, lvl);
    endtask

    task automatic hw_inval(input [15:0] did, input [38:0] addr, input int am, input string rq);
        iv_valid = 1; iv_did = did; iv_addr = addr[38:12]; iv_am = 5'(am);
        @(negedge clk);
        iv_valid = 0;
        checks++;
        if (iv_reject !== (am > 18)) begin
            errors++;
            $display("FAIL R11 (%s) iv_reject: got %b expected %b", rq, iv_reject, (am > 18));
        end
        m_inval(did, addr, am);
    endtask

    task automatic hw_flush();
        flush = 1;
        @(negedge clk);
        flush = 0;
        m_clear();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: empty after reset
        checks++;
        if (lk_done !== 0 || lk_hit !== 0 || iv_reject !== 0) begin
            errors++;
            $display("FAIL R1 reset outputs: got done=%b hit=%b rej=%b expected 0 0 0", lk_done, lk_hit, iv_reject);
        end
        for (int k = 0; k < 8; k++) look(16'(k), 39'(k) * 39'h0F_1234_5000, "R1 after reset");

        // Three page sizes for sid 1, domain 5
        hw_fill(16'h1, 16'h5, 39'h00_4060_3000, 39'h12_3456_7000, 1, 0, 1);
        hw_fill(16'h1, 16'h5, 39'h00_4060_0000, 39'h05_5540_0000, 1, 1, 2);
        hw_fill(16'h1, 16'h5, 39'h00_4000_0000, 39'h03_C000_0000, 0, 1, 3);
        for (int k = 0; k < 16; k++) look(16'h1, 39'h00_4060_3000 + 39'(k * 255), "R3 4K inside 2M inside 1G");
        for (int k = 0; k < 16; k++) look(16'h1, 39'h00_4060_0000 + 39'(k * 32'h1F00), "R3 around 4K page in 2M");
        for (int k = 0; k < 16; k++) look(16'h1, 39'h00_4000_0000 + 39'(k * 32'h0410_0000), "R4 1G region");
        for (int k = 0; k < 8; k++) look(16'h2, 39'h00_4060_3000 + 39'(k * 32'h0800_0000), "R2 other sid");
        look(16'h1, 39'h00_8000_0000, "R2 outside 1G");
        look(16'h1, 39'h00_3FFF_F000, "R2 below 1G");

        // R5: replacement by tag, permission sweep
        for (int p = 0; p < 4; p++) begin
            hw_fill(16'h1, 16'h5, 39'h00_4060_3ABC, 39'h00_ABCD_E000 + 39'(p << 12), p[0], p[1], 1);
            look(16'h1, 39'h00_4060_3123, "R5 refill same tag");
        end

        // R6: bad levels ignored
        hw_fill(16'h1, 16'h5, 39'h00_1000_0000, 39'h00_2000_0000, 1, 1, 0);
        hw_fill(16'h1, 16'h5, 39'h00_1000_0000, 39'h00_2000_0000, 1, 1, 4);
        hw_fill(16'h1, 16'h5, 39'h00_1000_0000, 39'h00_2000_0000, 1, 1, 7);
        look(16'h1, 39'h00_1000_0000, "R6 level 0/4/7 fill");

        // R10: other domain untouched
        hw_inval(16'h6, 39'h00_4060_3000, 0, "R10");
        look(16'h1, 39'h00_4060_3000, "R10 wrong domain");
        look(16'h1, 39'h00_4060_5000, "R10 wrong domain");
        look(16'h1, 39'h00_4100_0000, "R10 wrong domain");

        // R11: order above 18 refused
        hw_inval(16'h5, 39'h00_4060_3000, 19, "R11 am 19");
        hw_inval(16'h5, 39'h00_4060_3000, 31, "R11 am 31");
        look(16'h1, 39'h00_4060_3000, "R11 nothing removed");
        look(16'h1, 39'h00_4100_0000, "R11 nothing removed");

        // R8: range invalidation on a run of 4K pages
        for (int k = 0; k < 8; k++)
            hw_fill(16'h3, 16'h7, 39'h00_2000_0000 + 39'(k << 12), 39'h00_3000_0000 + 39'(k << 12), 1, 1, 1);
        hw_inval(16'h7, 39'h00_2000_4000, 2, "R8");
        for (int k = 0; k < 8; k++) look(16'h3, 39'h00_2000_0000 + 39'(k << 12), "R8 range invalidation");

        // R9: address inside the 1G page, am 0
        hw_inval(16'h5, 39'h00_7000_0000, 0, "R9");
        look(16'h1, 39'h00_7000_0000, "R9 covering large page");
        look(16'h1, 39'h00_4060_3000, "R9 small page kept");
        look(16'h1, 39'h00_4061_0000, "R9 2M page kept");

        // R12: lookup and invalidate in one cycle
        lk_valid = 1; lk_sid = 16'h1; lk_addr = 27'h0_4060_3;
        iv_valid = 1; iv_did = 16'h5; iv_addr = 27'h0_4060_3; iv_am = 0;
        @(negedge clk);
        lk_valid = 0; iv_valid = 0;
        chk_lk(16'h1, 39'h00_4060_3000, "R12 lookup with invalidate");
        m_inval(16'h5, 39'h00_4060_3000, 0);
        look(16'h1, 39'h00_4060_3000, "R12 after invalidate");
        look(16'h1, 39'h00_4061_0000, "R12 after invalidate");

        // R12: lookup and flush in one cycle
        lk_valid = 1; lk_sid = 16'h3; lk_addr = 27'h0_2000_1;
        flush = 1;
        @(negedge clk);
        lk_valid = 0; flush = 0;
        chk_lk(16'h3, 39'h00_2000_1000, "R12 lookup with flush");
        m_clear();
        for (int k = 0; k < 4; k++) look(16'h3, 39'h00_2000_0000 + 39'(k << 12), "R1 after flush");

        // R13: fill with flush dropped, fill with invalidate kept
        fl_valid = 1; fl_sid = 16'h4; fl_did = 16'h9; fl_addr = 27'h0_5000_0;
        fl_leaf_base = 27'h0_6000_0; fl_rd = 1; fl_wr = 1; fl_level = 3'd1;
        flush = 1;
        @(negedge clk);
        fl_valid = 0; flush = 0;
        look(16'h4, 39'h00_5000_0000, "R13 fill with flush");
        fl_valid = 1; iv_valid = 1; iv_did = 16'h9; iv_addr = 27'h0_5000_0; iv_am = 0;
        @(negedge clk);
        fl_valid = 0; iv_valid = 0;
        m_fill(16'h4, 16'h9, 39'h00_5000_0000, 39'h00_6000_0000, 1, 1, 1);
        look(16'h4, 39'h00_5000_0000, "R13 fill with invalidate");

        // R7: capacity and round-robin victim
        hw_flush();
        for (int k = 0; k < N; k++)
            hw_fill(16'h2, 16'h8, 39'h00_0100_0000 + 39'(k << 12), 39'h00_0200_0000 + 39'(k << 12), 1, 0, 1);
        for (int k = 0; k < N; k++) look(16'h2, 39'h00_0100_0000 + 39'(k << 12), "R7 full array");
        for (int k = N; k < N + 3; k++)
            hw_fill(16'h2, 16'h8, 39'h00_0100_0000 + 39'(k << 12), 39'h00_0200_0000 + 39'(k << 12), 0, 1, 1);
        for (int k = 0; k < N + 3; k++) look(16'h2, 39'h00_0100_0000 + 39'(k << 12), "R7 victim order");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule